// File: doc/BRIEF.md
# PCM Line Code Format Converter

This block sits between a codec's internal companded sample code and the 8-bit serial PCM word carried on the line. The internal code puts the polarity in bit 7, a 3-bit chord (segment) number in bits 6:4, and a 4-bit step within that chord in bits 3:0. Bit 7 is the first bit shifted out on the serial line.

On the line the word can take one of three conventions, chosen by a shared format select. The first is plain sign and magnitude. The second keeps the true sign and inverts the magnitude bits. The third inverts every other bit, which is the convention used for A-law words. Each of the three is a fixed XOR mask over the same field layout, so applying it twice returns the original word. The block therefore has two identical registered lanes. The transmit lane turns internal code into line code. The receive lane turns line code back into internal code.

Each lane registers its converted word only when its input strobe is high. It raises its output strobe one clock after the input strobe. Reset is asserted asynchronously and released on a clock edge.

Top module: `pcm_code_conv`

## Requirements
- R1: Bit 7 carries the sign and no format ever alters it. Bits 6:4 (chord) and 3:0 (step) are the only fields a format may invert.
- R2: Format select 0 (sign-magnitude) passes the word through unchanged. A full-scale positive sample 8'hFF leaves as 8'hFF.
- R3: Format select 1 keeps bit 7 and inverts bits 6:0 (mask 8'h7F). A full-scale positive sample 8'hFF leaves as 8'h80.
- R4: Format select 2 inverts bits 0, 2, 4 and 6 (mask 8'h55). Positive zero level 8'h80 leaves as 8'hD5, and positive overload 8'hFF leaves as 8'hAA.
- R5: Format select 3 behaves exactly as format select 0.
- R6: The receive lane applies the same mask as the transmit lane, so a word converted by transmit and fed back through receive with the same format returns unchanged.
- R7: A lane's output word changes only in the clock after its input strobe is high. It holds its value while the strobe is low.
- R8: A lane's output strobe equals its input strobe delayed by exactly one clock.
- R9: While reset is asserted, and until the first accepted word after it, both output words read 8'h00 and both output strobes are low.
- R10: The two lanes run independently and may both accept a word in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Line format: 0 sign-magnitude, 1 inverted magnitude, 2 alternate-bit inversion, 3 as 0 |
| tx_vld_i | input | 1 | Transmit input strobe |
| tx_word_i | input | 8 | Internal code to be sent |
| tx_vld_o | output | 1 | Transmit output strobe |
| tx_word_o | output | 8 | Line code word |
| rx_vld_i | input | 1 | Receive input strobe |
| rx_word_i | input | 8 | Received line code word |
| rx_vld_o | output | 1 | Receive output strobe |
| rx_word_o | output | 8 | Recovered internal code |

## Verification
The assertions are evaluated on every cycle and cover the following:
- the one-clock strobe delay in both lanes;
- holding the output word while the strobe is low;
- preservation of the sign bit;
- the transmit mask for each format select value, including the out-of-range value.

Some properties can only be shown by the bench's scenarios:
- the round trip from transmit back through receive;
- the named code points for zero level, full scale and overload;
- the reset values;
- independent transfers on both lanes in the same clock.

// File: rtl/pcm_conv_pkg.sv
package pcm_conv_pkg;
  localparam int FMT_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_SIGN_MAG = 2'd0,
    FMT_INV_MAG  = 2'd1,
    FMT_ALT_INV  = 2'd2,
    FMT_RSVD     = 2'd3
  } line_fmt_e;
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pcm_fmt_mask.sv
module pcm_fmt_mask
  import pcm_conv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FMT_W-1:0] fmt_sel,
  output logic [W-1:0]     mask
);
  localparam logic [W-1:0] MAG_MASK = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] alt_mask;

  for (genvar i = 0; i < W; i++) begin : g_alt
    assign alt_mask[i] = ((i % 2) == 0) && (i < W - 1);
  end

  always_comb begin
    unique case (line_fmt_e'(fmt_sel))
      FMT_INV_MAG: mask = MAG_MASK;
      FMT_ALT_INV: mask = alt_mask;
      default:     mask = '0;
    endcase
  end

  always_comb begin
    AST_SIGN_UNMASKED: assert (mask[W-1] == 1'b0); // R1
  end
endmodule

// File: rtl/pcm_fmt_lane.sv
module pcm_fmt_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mask,
  input  logic         vld_i,
  input  logic [W-1:0] word_i,
  output logic         vld_o,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_d, word_q;
  logic         vld_q;

  always_comb begin
    word_d = word_q;
    if (vld_i) word_d = word_i ^ mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_i;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o); // R8
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(word_o)); // R7
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (word_o[W-1] == $past(word_i[W-1]))); // R1
endmodule

// File: rtl/pcm_code_conv.sv
module pcm_code_conv
  import pcm_conv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FMT_W-1:0] fmt_sel,
  input  logic             tx_vld_i,
  input  logic [W-1:0]     tx_word_i,
  output logic             tx_vld_o,
  output logic [W-1:0]     tx_word_o,
  input  logic             rx_vld_i,
  input  logic [W-1:0]     rx_word_i,
  output logic             rx_vld_o,
  output logic [W-1:0]     rx_word_o
);
  localparam int NUM_LANES = 2;
  localparam int LANE_TX   = 0;
  localparam int LANE_RX   = 1;

  logic         rst_n_sync;
  logic [W-1:0] mask;
  logic         lane_vld_i [NUM_LANES];
  logic [W-1:0] lane_word_i[NUM_LANES];
  logic         lane_vld_o [NUM_LANES];
  logic [W-1:0] lane_word_o[NUM_LANES];

  pcm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pcm_fmt_mask #(.W(W)) i_mask (
    .fmt_sel (fmt_sel),
    .mask    (mask)
  );

  assign lane_vld_i[LANE_TX]  = tx_vld_i;
  assign lane_word_i[LANE_TX] = tx_word_i;
  assign lane_vld_i[LANE_RX]  = rx_vld_i;
  assign lane_word_i[LANE_RX] = rx_word_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pcm_fmt_lane #(.W(W)) i_lane (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .mask   (mask),
      .vld_i  (lane_vld_i[g]),
      .word_i (lane_word_i[g]),
      .vld_o  (lane_vld_o[g]),
      .word_o (lane_word_o[g])
    );
  end

  assign tx_vld_o  = lane_vld_o[LANE_TX];
  assign tx_word_o = lane_word_o[LANE_TX];
  assign rx_vld_o  = lane_vld_o[LANE_RX];
  assign rx_word_o = lane_word_o[LANE_RX];

  AST_FMT_PASS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_vld_i && (fmt_sel == 2'd0)) |=> (tx_word_o == $past(tx_word_i))); // R2
  AST_FMT_RSVD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_vld_i && (fmt_sel == 2'd3)) |=> (tx_word_o == $past(tx_word_i))); // R5
  AST_FMT_INV_MAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_vld_i && (fmt_sel == 2'd1)) |=>
      (tx_word_o == {$past(tx_word_i[W-1]), ~$past(tx_word_i[W-2:0])})); // R3
  AST_FMT_ALT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_vld_i && (fmt_sel == 2'd2)) |=>
      (tx_word_o[0] != $past(tx_word_i[0])) && (tx_word_o[1] == $past(tx_word_i[1]))); // R4
endmodule

// File: tb/test_pcm_code_conv.sv
module test_pcm_code_conv;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt_sel = '0;
  logic         tx_vld_i = 1'b0, rx_vld_i = 1'b0;
  logic [W-1:0] tx_word_i = '0, rx_word_i = '0;
  logic         tx_vld_o, rx_vld_o;
  logic [W-1:0] tx_word_o, rx_word_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [W-1:0] tx_q[$];
  string        tx_tag[$];
  logic [W-1:0] rx_q[$];
  string        rx_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_code_conv #(.W(W)) i_pcm_code_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .tx_vld_i  (tx_vld_i),
    .tx_word_i (tx_word_i),
    .tx_vld_o  (tx_vld_o),
    .tx_word_o (tx_word_o),
    .rx_vld_i  (rx_vld_i),
    .rx_word_i (rx_word_i),
    .rx_vld_o  (rx_vld_o),
    .rx_word_o (rx_word_o)
  );

  function automatic logic [W-1:0] fmt_mask(input logic [1:0] f);
    case (f)
      2'd1:    return 8'h7F;
      2'd2:    return 8'h55;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] f, input bit use_tx, input logic [W-1:0] txw,
                       input bit use_rx, input logic [W-1:0] rxw, input string tag);
    @(negedge clk);
    fmt_sel   = f;
    tx_vld_i  = use_tx;
    tx_word_i = txw;
    rx_vld_i  = use_rx;
    rx_word_i = rxw;
    if (use_tx) begin tx_q.push_back(txw ^ fmt_mask(f)); tx_tag.push_back(tag); end
    if (use_rx) begin rx_q.push_back(rxw ^ fmt_mask(f)); rx_tag.push_back(tag); end
    @(negedge clk);
    tx_vld_i = 1'b0;
    rx_vld_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_vld_o) begin
      if (tx_q.size() == 0) check("R8 tx spurious strobe", 8'h01, 8'h00);
      else check(tx_tag.pop_front(), tx_word_o, tx_q.pop_front());
    end
    if (rst_n && rx_vld_o) begin
      if (rx_q.size() == 0) check("R8 rx spurious strobe", 8'h01, 8'h00);
      else check(rx_tag.pop_front(), rx_word_o, rx_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 tx word in reset", tx_word_o, 8'h00);
    check("R9 rx word in reset", rx_word_o, 8'h00);
    check("R9 strobes in reset", {6'd0, tx_vld_o, rx_vld_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 tx word after reset", tx_word_o, 8'h00);

    drive(2'd0, 1, 8'hFF, 0, 8'h00, "R2 full scale sign-mag");
    drive(2'd0, 1, 8'h3A, 0, 8'h00, "R2 passthrough");
    drive(2'd1, 1, 8'hFF, 0, 8'h00, "R3 full scale inverted magnitude");
    drive(2'd1, 1, 8'h05, 0, 8'h00, "R3 negative sample");
    drive(2'd2, 1, 8'h80, 0, 8'h00, "R4 positive zero level");
    drive(2'd2, 1, 8'hFF, 0, 8'h00, "R4 positive overload");
    drive(2'd3, 1, 8'hC7, 0, 8'h00, "R5 reserved select");
    drive(2'd1, 1, 8'h00, 0, 8'h00, "R1 sign zero kept");

    // R4/R3 literal code points checked directly at the port
    drive(2'd2, 1, 8'hFF, 0, 8'h00, "R4 overload repeat");
    check("R4 overload code 10101010", tx_word_o, 8'hAA);
    drive(2'd1, 1, 8'hFF, 0, 8'h00, "R3 repeat");
    check("R3 full scale code 10000000", tx_word_o, 8'h80);

    // R7: strobe low, new data must not reach output
    @(negedge clk);
    tx_word_i = 8'h11;
    rx_word_i = 8'h22;
    repeat (2) @(negedge clk);
    check("R7 tx hold with strobe low", tx_word_o, 8'h80);
    check("R7 rx hold with strobe low", rx_word_o, 8'h00);

    // R6 round trip for every format
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 4; k++) begin
        logic [W-1:0] orig;
        logic [W-1:0] line;
        orig = 8'(k * 67 + f * 29 + 3);
        drive(2'(f), 1, orig, 0, 8'h00, "R6 transmit leg");
        line = tx_word_o;
        drive(2'(f), 0, 8'h00, 1, line, "R6 receive leg");
        check("R6 round trip", rx_word_o, orig);
      end
    end

    // R10 both lanes in the same clock
    drive(2'd2, 1, 8'h9C, 1, 8'h63, "R10 simultaneous lanes");
    drive(2'd1, 1, 8'h2E, 1, 8'hD1, "R10 simultaneous lanes");

    repeat (3) @(negedge clk);
    check("R8 tx queue drained", 8'(tx_q.size()), 8'h00);
    check("R8 rx queue drained", 8'(rx_q.size()), 8'h00);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule